// File: doc/BRIEF.md
# DDR Read-Turnaround Command Spacer

This block sits between a DDR SDRAM command scheduler and the command bus. It enforces the minimum number of clocks that must pass after a read command before a write, or a read to a different row, may be issued. A read burst of length 4 cannot be cut short by a following write or by a read to another row. The required gap therefore depends only on burst length, CAS latency and bus turnaround. It is set by two small coded configuration fields, not by a free-running timing count.

The scheduler presents one command at a time on a valid/ready handshake. `cmd_valid` together with the payload (`cmd_is_wr`, `cmd_diff_row`) offers a command. `cmd_ready` says whether that command may go out in this cycle. `cmd_ready` depends on the payload, and it is low during reset. A command is accepted in any cycle in which both are high, and `cmd_grant` pulses in that cycle. While `cmd_ready` is low the scheduler keeps `cmd_valid` high and holds the payload steady. This back-pressure lasts until the gap has run out. Two countdown timers, one per gap type, are reloaded each time a read is accepted. `busy` is high while either timer is still running.

The read-to-write gap equals CL + 2 + turnaround − 1 clocks, which gives 4 to 7 clocks. The different-row read-to-read gap equals 2 + turnaround clocks, which gives 3 or 4 clocks. For example, CL=2 with a turnaround of 1 needs read-to-write code 11, which is 4 clocks. The configuration seen by the timers is frozen while a countdown runs.

Top module: `ddr_cmd_spacer`

## Requirements
- R1: Synchronous active-high reset clears both timers. In the first cycle after reset `busy` is 0, and any command (write, or read to either row) is granted in the cycle it is offered.
- R2: The read-to-write field `cfg_rw_gap[1:0]` decodes as 00→7, 01→6, 10→5, 11→4 clocks. A write offered from the cycle after a read is accepted is granted exactly that many cycles after the read's grant, and never sooner.
- R3: The read-to-read field `cfg_rr_gap` decodes as 0→4 and 1→3 clocks. A read with `cmd_diff_row`=1 offered after a read is accepted is granted exactly that many cycles after the read's grant.
- R4: A read with `cmd_diff_row`=0 is granted in the cycle it is offered, even while `busy` is 1. Its acceptance restarts both gaps from its own grant cycle.
- R5: Writes load no timer. A write offered while `busy` is 0 is granted at once, so back-to-back writes are granted in consecutive cycles. `cmd_diff_row` has no effect on a write.
- R6: `cmd_grant` is high only in a cycle where `cmd_valid` and `cmd_ready` are both high. With `cmd_valid` low there is no grant.
- R7: The configuration is taken from the input pins only while `busy` is 0. A field change made during a countdown does not alter the gap in progress. A change made while idle applies to the very next read.
- R8: `busy` rises in the cycle after a read is accepted. It stays high until the longer of the two gaps ends, and is 0 in the first cycle in which a write would be granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rw_gap | input | 2 | Coded read-to-write spacing (00→7 … 11→4 clocks) |
| cfg_rr_gap | input | 1 | Coded different-row read-to-read spacing (0→4, 1→3 clocks) |
| cmd_valid | input | 1 | Scheduler offers a command |
| cmd_is_wr | input | 1 | 1 = write, 0 = read |
| cmd_diff_row | input | 1 | Read targets a different row than the previous read |
| cmd_ready | output | 1 | Offered command may issue this cycle |
| cmd_grant | output | 1 | Single-cycle pulse: command accepted |
| busy | output | 1 | A spacing countdown is running |

## Verification
If a timer holds a wrong count, the next write or different-row read is granted on the wrong cycle. The error shows as a grant one or more cycles early or late relative to the read's grant, within at most seven cycles, so every gap is measured to the exact cycle. If the configuration hold is wrong, the gap in progress changes length when a field is rewritten mid-countdown. If the idle path is wrong, the first read after a change is mis-spaced, and both cases are exercised. A stuck busy flag or a timer that never reloads shows as `busy` at the wrong level, or as a same-row read failing to push out a pending write.

// File: rtl/ddr_cmd_spacer_pkg.sv
package ddr_cmd_spacer_pkg;

  // index of each spacing timer
  typedef enum logic [0:0] {
    GAP_RD_WR = 1'b0,
    GAP_RD_RD = 1'b1
  } gap_kind_e;

  localparam int NUM_GAPS = 2;

  // reload value for a coded gap: slowest setting minus code, minus the
  // grant cycle itself
  function automatic int unsigned gap_reload(input int unsigned slowest,
                                             input int unsigned code);
    return slowest - code - 1;
  endfunction

endpackage

// File: rtl/ddr_cmd_spacer_cfg_hold.sv
module ddr_cmd_spacer_cfg_hold #(
  parameter int RW_CODE_W = 2,
  parameter int RR_CODE_W = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hold,
  input  logic [RW_CODE_W-1:0] rw_code_in,
  input  logic [RR_CODE_W-1:0] rr_code_in,
  output logic [RW_CODE_W-1:0] rw_code_eff,
  output logic [RR_CODE_W-1:0] rr_code_eff
);

  logic [RW_CODE_W-1:0] rw_shadow;
  logic [RR_CODE_W-1:0] rr_shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      rw_shadow <= '0;
      rr_shadow <= '0;
    end else if (!hold) begin
      rw_shadow <= rw_code_in;
      rr_shadow <= rr_code_in;
    end
  end

  // idle: pins act at once; counting: frozen copy from the last idle cycle
  always_comb begin
    rw_code_eff = hold ? rw_shadow : rw_code_in;
    rr_code_eff = hold ? rr_shadow : rr_code_in;
  end

endmodule

// File: rtl/ddr_cmd_spacer_timer.sv
module ddr_cmd_spacer_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             running
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - CNT_W'(1);
    end
  end

  assign running = (remain != '0);

endmodule

// File: rtl/ddr_cmd_spacer_gate.sv
module ddr_cmd_spacer_gate (
  input  logic rst,
  input  logic cmd_valid,
  input  logic cmd_is_wr,
  input  logic cmd_diff_row,
  input  logic rw_running,
  input  logic rr_running,
  output logic cmd_ready,
  output logic cmd_grant,
  output logic rd_accept
);

  always_comb begin
    if (rst) begin
      cmd_ready = 1'b0;
    end else if (cmd_is_wr) begin
      cmd_ready = !rw_running;
    end else if (cmd_diff_row) begin
      cmd_ready = !rr_running;
    end else begin
      cmd_ready = 1'b1;
    end
    cmd_grant = cmd_valid && cmd_ready;
    rd_accept = cmd_grant && !cmd_is_wr;
  end

endmodule

// File: rtl/ddr_cmd_spacer.sv
module ddr_cmd_spacer
  import ddr_cmd_spacer_pkg::*;
#(
  parameter int RW_CODE_W   = 2,
  parameter int RR_CODE_W   = 1,
  parameter int RW_SLOW_GAP = 7,
  parameter int RR_SLOW_GAP = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [RW_CODE_W-1:0] cfg_rw_gap,
  input  logic [RR_CODE_W-1:0] cfg_rr_gap,
  input  logic                 cmd_valid,
  input  logic                 cmd_is_wr,
  input  logic                 cmd_diff_row,
  output logic                 cmd_ready,
  output logic                 cmd_grant,
  output logic                 busy
);

  localparam int MAX_GAP = (RW_SLOW_GAP > RR_SLOW_GAP) ? RW_SLOW_GAP : RR_SLOW_GAP;
  localparam int CNT_W   = $clog2(MAX_GAP);

  logic [RW_CODE_W-1:0] eff_rw_code;
  logic [RR_CODE_W-1:0] eff_rr_code;
  logic [NUM_GAPS-1:0]  running;
  logic [CNT_W-1:0]     reload [NUM_GAPS];
  logic                 rd_accept;

  ddr_cmd_spacer_cfg_hold #(
    .RW_CODE_W (RW_CODE_W),
    .RR_CODE_W (RR_CODE_W)
  ) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .hold        (busy),
    .rw_code_in  (cfg_rw_gap),
    .rr_code_in  (cfg_rr_gap),
    .rw_code_eff (eff_rw_code),
    .rr_code_eff (eff_rr_code)
  );

  always_comb begin
    reload[GAP_RD_WR] = CNT_W'(gap_reload(RW_SLOW_GAP, int'(eff_rw_code)));
    reload[GAP_RD_RD] = CNT_W'(gap_reload(RR_SLOW_GAP, int'(eff_rr_code)));
  end

  for (genvar g = 0; g < NUM_GAPS; g++) begin : g_timer
    ddr_cmd_spacer_timer #(
      .CNT_W (CNT_W)
    ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (rd_accept),
      .load_val (reload[g]),
      .running  (running[g])
    );
  end

  ddr_cmd_spacer_gate u_gate (
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_is_wr    (cmd_is_wr),
    .cmd_diff_row (cmd_diff_row),
    .rw_running   (running[GAP_RD_WR]),
    .rr_running   (running[GAP_RD_RD]),
    .cmd_ready    (cmd_ready),
    .cmd_grant    (cmd_grant),
    .rd_accept    (rd_accept)
  );

  assign busy = |running;

endmodule

// File: rtl/ddr_cmd_spacer_chk.sv
module ddr_cmd_spacer_chk #(
  parameter int RW_CODE_W = 2,
  parameter int RR_CODE_W = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cmd_valid,
  input logic                 cmd_is_wr,
  input logic                 cmd_diff_row,
  input logic                 cmd_ready,
  input logic                 cmd_grant,
  input logic                 busy,
  input logic [RW_CODE_W-1:0] eff_rw_code,
  input logic [RR_CODE_W-1:0] eff_rr_code
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !busy);

  // R2
  early_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_grant && !cmd_is_wr) |=> !(cmd_grant && cmd_is_wr));

  // R4
  same_row_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_is_wr && !cmd_diff_row) |-> cmd_ready);

  // R5
  idle_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_is_wr && !busy) |-> cmd_grant);

  // R6
  grant_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_grant |-> cmd_valid);

  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(eff_rw_code) && $stable(eff_rr_code)));

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_grant && !cmd_is_wr) |=> busy);

endmodule

bind ddr_cmd_spacer ddr_cmd_spacer_chk #(
  .RW_CODE_W (RW_CODE_W),
  .RR_CODE_W (RR_CODE_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_valid    (cmd_valid),
  .cmd_is_wr    (cmd_is_wr),
  .cmd_diff_row (cmd_diff_row),
  .cmd_ready    (cmd_ready),
  .cmd_grant    (cmd_grant),
  .busy         (busy),
  .eff_rw_code  (eff_rw_code),
  .eff_rr_code  (eff_rr_code)
);

// File: tb/ddr_cmd_spacer_bench.sv
module ddr_cmd_spacer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_rw_gap = 2'b00;
  logic       cfg_rr_gap = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_is_wr = 1'b0;
  logic       cmd_diff_row = 1'b0;
  logic       cmd_ready;
  logic       cmd_grant;
  logic       busy;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  ddr_cmd_spacer u_ddr_cmd_spacer (
    .clk          (clk),
    .rst          (rst),
    .cfg_rw_gap   (cfg_rw_gap),
    .cfg_rr_gap   (cfg_rr_gap),
    .cmd_valid    (cmd_valid),
    .cmd_is_wr    (cmd_is_wr),
    .cmd_diff_row (cmd_diff_row),
    .cmd_ready    (cmd_ready),
    .cmd_grant    (cmd_grant),
    .busy         (busy)
  );

  // vector: [7:6] rw code, [5] rr code, [4] second is write,
  //         [3] second diff row, [2:0] expected gap in clocks
  localparam logic [7:0] VECS [8] = '{
    8'b00_0_1_0_111,  // R2 00 -> 7
    8'b01_0_1_0_110,  // R2 01 -> 6
    8'b10_1_1_1_101,  // R2 10 -> 5, diff flag on write ignored (R5)
    8'b11_0_1_0_100,  // R2 11 -> 4
    8'b00_0_0_1_100,  // R3 0 -> 4
    8'b01_1_0_1_011,  // R3 1 -> 3
    8'b11_1_0_0_001,  // R4 same row next cycle
    8'b11_0_0_1_100   // R3 0 -> 4 with other rw code
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // at a negedge: offer a command and return whether it is granted now
  task automatic offer(input logic wr, input logic diff, output logic g);
    cmd_valid = 1'b1;
    cmd_is_wr = wr;
    cmd_diff_row = diff;
    #1;
    g = cmd_grant;
  endtask

  // finish the current accepted cycle and drop valid at next negedge
  task automatic finish_cmd();
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // called at the negedge just after a read was accepted; holds the
  // second command until granted and returns the gap in clocks
  task automatic measure(input logic wr, input logic diff, output int k);
    logic g;
    k = 1;
    offer(wr, diff, g);
    while (!g && k < 16) begin
      @(posedge clk);
      @(negedge clk);
      k++;
      #1;
      g = cmd_grant;
    end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    #1;
    while (busy && n < 20) begin
      @(negedge clk);
      n++;
      #1;
    end
  endtask

  // accept a read now (at negedge), step to the following negedge
  task automatic read_now(input logic diff, input string req);
    logic g;
    offer(1'b0, diff, g);
    check(req, int'(g), 1);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic g;
    int   k;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state and immediate first grants
    check("R1 busy after reset", int'(busy), 0);
    offer(1'b0, 1'b1, g);
    check("R1 first diff-row read granted", int'(g), 1);
    cmd_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    offer(1'b1, 1'b0, g);
    check("R1 first write granted", int'(g), 1);
    finish_cmd();

    // table walk: R2 R3 R4
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = VECS[i];
      cfg_rw_gap = v[7:6];
      cfg_rr_gap = v[5];
      drain();
      @(negedge clk);
      read_now(1'b0, "R2 table read");
      measure(v[4], v[3], k);
      check($sformatf("R2/R3/R4 vector %0d gap", i), k, int'(v[2:0]));
      drain();
    end

    // R5 write after write in consecutive cycles
    @(negedge clk);
    offer(1'b1, 1'b0, g);
    check("R5 first write", int'(g), 1);
    @(posedge clk);
    @(negedge clk);
    offer(1'b1, 1'b1, g);
    check("R5 second write next cycle", int'(g), 1);
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R5 busy after writes", int'(busy), 0);
    cmd_valid = 1'b0;

    // R6 no valid, no grant
    cmd_is_wr = 1'b0;
    cmd_diff_row = 1'b0;
    #1;
    check("R6 grant without valid", int'(cmd_grant), 0);

    // R8 busy window with rw=00 (7 clocks)
    cfg_rw_gap = 2'b00;
    cfg_rr_gap = 1'b0;
    @(negedge clk);
    read_now(1'b0, "R8 read");
    #1;
    check("R8 busy cycle 1", int'(busy), 1);
    repeat (5) @(negedge clk);
    #1;
    check("R8 busy cycle 6", int'(busy), 1);
    @(negedge clk);
    #1;
    check("R8 busy cycle 7", int'(busy), 0);

    // R7 change during countdown does not shorten gap
    @(negedge clk);
    cfg_rw_gap = 2'b00;
    read_now(1'b0, "R7 read");
    cfg_rw_gap = 2'b11;
    measure(1'b1, 1'b0, k);
    check("R7 gap after mid-change", k, 7);
    drain();
    // R7 idle change applies to very next read
    @(negedge clk);
    read_now(1'b0, "R7 read idle");
    measure(1'b1, 1'b0, k);
    check("R7 gap after idle change", k, 4);
    drain();

    // R4 same-row read restarts the gap
    cfg_rw_gap = 2'b00;
    @(negedge clk);
    read_now(1'b0, "R4 first read");
    @(negedge clk);
    read_now(1'b0, "R4 same-row read while busy");
    measure(1'b1, 1'b0, k);
    check("R4 write gap restarted", k, 7);
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule